// File: doc/BRIEF.md
# Nametable-Latched Character Address Substitution

This block sits between the picture unit's address bus and an 8 KiB character RAM. It watches the picture unit's nametable reads and keeps two bits of the last nametable address it saw: the row-half bit and the lowest bit. On later character reads it can put those kept bits in place of two character address bits. It replaces the 4 KiB page-select bit, which gives background art 512 distinct tiles split across the screen. It can also replace the bit-plane select bit, which turns the whole RAM into a one-bit-per-pixel bitmap that can be addressed point by point.

Three control inputs drive the block. `tall_mode` enables page substitution. `bitmap_mode` adds plane substitution, but only while `tall_mode` is set. `spr_upper` pins sprite fetches to the upper 4 KiB page while `tall_mode` is set. Writes to character RAM always pass through unchanged. The two kept bits are registered. The substitution itself is combinational, so the output for an access uses only what was captured before that access.

Top module: `nt_chr_subst`

## Requirements
- R1: After reset both kept bits are 0. A read with `tall_mode` and `bitmap_mode` set, before any capture, drives `chr_addr[12]` and `chr_addr[3]` to 0.
- R2: A capture happens on a clock edge where `ppu_rd`, `nt_sel` and `ppu_addr[13]` are all 1. It stores `ppu_addr[9]` as the page bit and `ppu_addr[0]` as the plane bit. The new values affect outputs from the next cycle on, and never the capturing access itself.
- R3: When any of `ppu_rd`, `nt_sel` or `ppu_addr[13]` is 0, the kept bits hold. This covers nametable writes, and reads with `ppu_addr[13]` clear even when `nt_sel` is high.
- R4: With `ppu_rd` at 0 (a write), `chr_addr` equals `ppu_addr[12:0]` whatever the mode inputs are.
- R5: With `tall_mode` at 0, reads pass through unchanged. Both `bitmap_mode` and `spr_upper` then have no effect.
- R6: On a read with `tall_mode` set and `spr_fetch` at 0, `chr_addr[12]` equals the kept page bit.
- R7: On a sprite read (`spr_fetch`=1) with `tall_mode` set and `spr_upper` clear, `chr_addr[12]` equals the kept page bit.
- R8: On a sprite read with `tall_mode` and `spr_upper` both set, `chr_addr[12]` is 1.
- R9: On any read with `tall_mode` and `bitmap_mode` both set, `chr_addr[3]` equals the kept plane bit. This applies to background and sprite reads alike.
- R10: All `chr_addr` bits other than 12 and 3 always equal the matching `ppu_addr` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Picture unit clock |
| rst_n | input | 1 | Active-low reset, clears the kept bits |
| ppu_addr | input | 14 | Picture unit address |
| ppu_rd | input | 1 | 1 = read access, 0 = write |
| nt_sel | input | 1 | Access targets nametable space |
| spr_fetch | input | 1 | Current access is a sprite pattern fetch |
| tall_mode | input | 1 | Enable page-bit substitution |
| bitmap_mode | input | 1 | Enable plane-bit substitution (needs `tall_mode`) |
| spr_upper | input | 1 | Force sprite fetches to upper page (needs `tall_mode`) |
| chr_addr | output | 13 | Address to the character RAM |

## Verification
The bench builds the block with its default parameters. These are a 14-bit picture address and a 13-bit character address, with substitution at bits 12 and 3 and capture from bits 9 and 0. With these values a random 14-bit address can hit every combination of the two captured bits, the region bit and the two substituted positions. Directed steps cover reset, capture timing on the capturing access itself, and the holds on writes and on reads with bit 13 clear. A long random run then drives every combination of the mode inputs against the behavioural model.

// File: rtl/nt_chr_subst_pkg.sv
package nt_chr_subst_pkg;

  typedef struct packed {
    logic tall;    // page-bit substitution
    logic bitmap;  // plane-bit substitution, qualified by tall
    logic spr_hi;  // sprite fetches forced to upper page, qualified by tall
  } subst_ctl_t;

  // Value driven onto the page-select bit of the character address.
  function automatic logic pick_tile_bit(logic raw, logic kept, logic rd,
                                         subst_ctl_t c, logic spr);
    if (!rd || !c.tall) return raw;
    if (spr && c.spr_hi) return 1'b1;
    return kept;
  endfunction

  // Value driven onto the plane-select bit of the character address.
  function automatic logic pick_plane_bit(logic raw, logic kept, logic rd,
                                          subst_ctl_t c);
    return (rd && c.tall && c.bitmap) ? kept : raw;
  endfunction

endpackage

// File: rtl/nt_addr_snoop.sv
module nt_addr_snoop (
  input  logic clk,
  input  logic rst_n,
  input  logic rd,
  input  logic nt_sel,
  input  logic region_bit,
  input  logic src_hi,
  input  logic src_lo,
  output logic kept_hi,
  output logic kept_lo,
  output logic capture
);

  assign capture = rd && nt_sel && region_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kept_hi <= 1'b0;
      kept_lo <= 1'b0;
    end else if (capture) begin
      kept_hi <= src_hi;
      kept_lo <= src_lo;
    end
  end

endmodule

// File: rtl/chr_addr_mux.sv
module chr_addr_mux
  import nt_chr_subst_pkg::*;
#(
  parameter int CHR_AW    = 13,
  parameter int TILE_BIT  = 12,
  parameter int PLANE_BIT = 3
) (
  input  logic [CHR_AW-1:0] raw,
  input  logic              rd,
  input  logic              spr,
  input  subst_ctl_t        ctl,
  input  logic              kept_hi,
  input  logic              kept_lo,
  output logic [CHR_AW-1:0] addr_out
);

  for (genvar g = 0; g < CHR_AW; g++) begin : g_bit
    if (g == TILE_BIT) begin : g_tile
      assign addr_out[g] = pick_tile_bit(raw[g], kept_hi, rd, ctl, spr);
    end else if (g == PLANE_BIT) begin : g_plane
      assign addr_out[g] = pick_plane_bit(raw[g], kept_lo, rd, ctl);
    end else begin : g_pass
      assign addr_out[g] = raw[g];
    end
  end

endmodule

// File: rtl/nt_chr_subst.sv
module nt_chr_subst
  import nt_chr_subst_pkg::*;
#(
  parameter int PPU_AW    = 14,
  parameter int CHR_AW    = 13,
  parameter int TILE_BIT  = 12,
  parameter int PLANE_BIT = 3,
  parameter int NT_HI_BIT = 9,
  parameter int NT_LO_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PPU_AW-1:0] ppu_addr,
  input  logic              ppu_rd,
  input  logic              nt_sel,
  input  logic              spr_fetch,
  input  logic              tall_mode,
  input  logic              bitmap_mode,
  input  logic              spr_upper,
  output logic [CHR_AW-1:0] chr_addr
);

  localparam int REGION_BIT = PPU_AW - 1;

  logic       kept_hi;
  logic       kept_lo;
  logic       capture;
  subst_ctl_t ctl;

  assign ctl = '{tall: tall_mode, bitmap: bitmap_mode, spr_hi: spr_upper};

  nt_addr_snoop u_snoop (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd        (ppu_rd),
    .nt_sel    (nt_sel),
    .region_bit(ppu_addr[REGION_BIT]),
    .src_hi    (ppu_addr[NT_HI_BIT]),
    .src_lo    (ppu_addr[NT_LO_BIT]),
    .kept_hi   (kept_hi),
    .kept_lo   (kept_lo),
    .capture   (capture)
  );

  chr_addr_mux #(
    .CHR_AW   (CHR_AW),
    .TILE_BIT (TILE_BIT),
    .PLANE_BIT(PLANE_BIT)
  ) u_mux (
    .raw     (ppu_addr[CHR_AW-1:0]),
    .rd      (ppu_rd),
    .spr     (spr_fetch),
    .ctl     (ctl),
    .kept_hi (kept_hi),
    .kept_lo (kept_lo),
    .addr_out(chr_addr)
  );

endmodule

// File: rtl/nt_chr_subst_chk.sv
module nt_chr_subst_chk #(
  parameter int PPU_AW    = 14,
  parameter int CHR_AW    = 13,
  parameter int TILE_BIT  = 12,
  parameter int PLANE_BIT = 3,
  parameter int NT_HI_BIT = 9,
  parameter int NT_LO_BIT = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PPU_AW-1:0] ppu_addr,
  input logic              ppu_rd,
  input logic              nt_sel,
  input logic              spr_fetch,
  input logic              tall_mode,
  input logic              bitmap_mode,
  input logic              spr_upper,
  input logic [CHR_AW-1:0] chr_addr,
  input logic              kept_hi,
  input logic              kept_lo
);

  logic nt_read;
  assign nt_read = ppu_rd && nt_sel && ppu_addr[PPU_AW-1];

  // R2
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nt_read |=> (kept_hi == $past(ppu_addr[NT_HI_BIT])) &&
                (kept_lo == $past(ppu_addr[NT_LO_BIT])));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nt_read |=> $stable(kept_hi) && $stable(kept_lo));

  // R4
  write_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ppu_rd |-> chr_addr == ppu_addr[CHR_AW-1:0]);

  // R5
  tall_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ppu_rd && !tall_mode) |-> chr_addr == ppu_addr[CHR_AW-1:0]);

  // R6
  bg_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ppu_rd && tall_mode && !spr_fetch) |-> chr_addr[TILE_BIT] == kept_hi);

  // R7
  spr_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ppu_rd && tall_mode && spr_fetch && !spr_upper) |-> chr_addr[TILE_BIT] == kept_hi);

  // R8
  spr_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ppu_rd && tall_mode && spr_fetch && spr_upper) |-> chr_addr[TILE_BIT]);

  // R9
  plane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ppu_rd && tall_mode && bitmap_mode) |-> chr_addr[PLANE_BIT] == kept_lo);

  // R10
  other_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones((chr_addr ^ ppu_addr[CHR_AW-1:0]) &
               ~((CHR_AW'(1) << TILE_BIT) | (CHR_AW'(1) << PLANE_BIT))) == 0);

endmodule

bind nt_chr_subst nt_chr_subst_chk #(
  .PPU_AW   (PPU_AW),
  .CHR_AW   (CHR_AW),
  .TILE_BIT (TILE_BIT),
  .PLANE_BIT(PLANE_BIT),
  .NT_HI_BIT(NT_HI_BIT),
  .NT_LO_BIT(NT_LO_BIT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ppu_addr   (ppu_addr),
  .ppu_rd     (ppu_rd),
  .nt_sel     (nt_sel),
  .spr_fetch  (spr_fetch),
  .tall_mode  (tall_mode),
  .bitmap_mode(bitmap_mode),
  .spr_upper  (spr_upper),
  .chr_addr   (chr_addr),
  .kept_hi    (kept_hi),
  .kept_lo    (kept_lo)
);

// File: tb/nt_chr_subst_bench.sv
`timescale 1ns/1ps
module nt_chr_subst_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] ppu_addr = '0;
  logic        ppu_rd = 1'b0, nt_sel = 1'b0, spr_fetch = 1'b0;
  logic        tall_mode = 1'b0, bitmap_mode = 1'b0, spr_upper = 1'b0;
  logic [12:0] chr_addr;

  int checks = 0;
  int errors = 0;
  int m_hi = 0;  // model of kept page bit
  int m_lo = 0;  // model of kept plane bit

  always #2.5 clk = ~clk;

  nt_chr_subst u_nt_chr_subst (
    .clk(clk), .rst_n(rst_n), .ppu_addr(ppu_addr), .ppu_rd(ppu_rd),
    .nt_sel(nt_sel), .spr_fetch(spr_fetch), .tall_mode(tall_mode),
    .bitmap_mode(bitmap_mode), .spr_upper(spr_upper), .chr_addr(chr_addr)
  );

  function automatic int expect_addr(int a, bit rd, bit spr, bit v, bit b, bit s);
    int r = a % 8192;
    if (rd && v) begin
      int page = (spr && s) ? 1 : m_hi;
      r = r - ((r / 4096) % 2) * 4096 + page * 4096;
      if (b) r = r - ((r / 8) % 2) * 8 + m_lo * 8;
    end
    return r;
  endfunction

  function automatic string pick_tag(bit rd, bit spr, bit v, bit s);
    if (!rd) return "R4";
    if (!v) return "R5";
    if (spr && s) return "R8";
    if (spr) return "R7";
    return "R6";
  endfunction

  task automatic cycle(input int a, input bit rd, input bit nt, input bit spr,
                       input bit v, input bit b, input bit s, input string tag);
    int exp;
    @(negedge clk);
    ppu_addr = 14'(a); ppu_rd = rd; nt_sel = nt; spr_fetch = spr;
    tall_mode = v; bitmap_mode = b; spr_upper = s;
    #1;
    exp = expect_addr(a, rd, spr, v, b, s);
    checks++;
    if (int'(chr_addr) != exp) begin
      errors++;
      $display("FAIL %s: chr_addr=%h expected %h (addr %h)", tag, chr_addr, exp[12:0], a[13:0]);
    end
    // R10: untouched bit positions follow the address
    checks++;
    if ((chr_addr & 13'h0FF7) != (13'(a) & 13'h0FF7)) begin
      errors++;
      $display("FAIL R10: chr_addr=%h expected low bits %h", chr_addr, 13'(a) & 13'h0FF7);
    end
    @(posedge clk);
    if (rd && nt && ((a / 8192) % 2 == 1)) begin
      m_hi = (a / 512) % 2;
      m_lo = a % 2;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: run incomplete, actual timeout, expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: kept bits cleared by reset
    cycle('h1FFF, 1, 0, 0, 1, 1, 0, "R1");
    // R2: capture page=1 plane=1; capturing access still sees old bits
    cycle('h2201, 1, 1, 0, 1, 1, 0, "R2");
    cycle('h0000, 1, 0, 0, 1, 1, 0, "R2");
    // R3: nametable write does not capture
    cycle('h2000, 0, 1, 0, 1, 1, 0, "R3");
    cycle('h0000, 1, 0, 0, 1, 1, 0, "R3");
    // R3: read with bit 13 clear while nt_sel high does not capture
    cycle('h0000, 1, 1, 0, 1, 1, 0, "R3");
    cycle('h0004, 1, 0, 0, 1, 1, 0, "R3");
    // R5: bitmap and sprite-force ignored without tall mode
    cycle('h0000, 1, 0, 1, 0, 1, 1, "R5");
    cycle('h0ABC, 1, 0, 0, 0, 1, 0, "R5");
    // capture page=0 plane=0
    cycle('h2C00, 1, 1, 0, 1, 0, 0, "R2");
    cycle('h1ABC, 1, 0, 1, 1, 0, 0, "R7");
    cycle('h0ABC, 1, 0, 1, 1, 0, 1, "R8");
    cycle('h1FFF, 1, 0, 0, 1, 1, 0, "R9");
    // R4: write with every mode set passes through
    cycle('h1123, 0, 0, 1, 1, 1, 1, "R4");
    cycle('h0008, 0, 0, 0, 1, 1, 0, "R4");
    for (int i = 0; i < 4000; i++) begin
      int  a   = int'($urandom_range(0, 16383));
      bit  rd  = ($urandom_range(0, 3) != 0);
      bit  nt  = ($urandom_range(0, 2) == 0);
      bit  spr = $urandom_range(0, 1) == 1;
      bit  v   = $urandom_range(0, 1) == 1;
      bit  b   = $urandom_range(0, 1) == 1;
      bit  s   = $urandom_range(0, 1) == 1;
      cycle(a, rd, nt, spr, v, b, s, pick_tag(rd, spr, v, s));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule